// File: doc/BRIEF.md
# Parallel ADC Command Sequencer

This block brings a bank of identical SPI converters out of reset and into free-running conversion. It does not shift bits itself. It talks to a separate SPI engine through two small registers. The first is a request word that the sequencer drives. The second is a status word that the engine returns. A command is handed over by loading one 16-bit word per converter, raising a start flag and waiting for the engine to acknowledge. For a one-shot command, a receive phase follows: the sequencer signals that it is ready for results, waits for the engine to report completion, then acknowledges and latches one result word per converter.

After reset the block pulses a clear to the status register and runs a fixed bring-up script. The script resets every converter, writes all-ones to the auto-sequence enable register, and idles for a programmable pause. It then issues an auto-sequence reset and publishes the initial inter-sample delay. Last, it sends a no-op with the continuous flag set. Every converter receives the same word at each step. A busy flag stays high until the engine has acknowledged that final continuous start.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: While reset is held, the request word is 0, the status-clear output is 1, the delay output is 0, the captured results are 0 and busy is 1.
- R2: Start (request bit 0) rises only after send-ready (status bit 0) has been seen. The command words are loaded before start rises and do not change while start is set.
- R3: Start stays set until send-ack (status bit 1) is seen. In the cycle after send-ack, start is cleared, and the continuous bit (request bit 1) keeps its value.
- R4: After a one-shot command is acknowledged, the request becomes 0x4 (receive-ready, bit 2). It stays there until send-done (status bit 2). Then it becomes 0x8 (receive-ack, bit 3). Start, receive-ready and receive-ack are never set together in any pair.
- R5: When send-done is accepted, one result word per converter is latched from the result bus and held on the captured-result output.
- R6: Command-register words carry the opcode in bits 15:8 and zero in bits 7:0: reset = 0x8500, auto-sequence reset = 0xA000, no-op = 0x0000. A program-register word is (address << 9) | (write << 8) | data. The enable step uses address 0x01, write = 1 and data 0xFF, giving 0x03FF.
- R7: Exactly four commands are issued, in the order reset, enable write, auto-sequence reset, no-op, and every converter gets the same word in each command.
- R8: Between the completed receive of the enable write and the start of the auto-sequence reset, at least PAUSE_CYC (default 200) cycles pass. With send-ready already high, no more than PAUSE_CYC+8 cycles pass.
- R9: The delay output is 0 until the auto-sequence reset receive completes. It then holds INIT_DELAY (default 781) before the continuous start and afterwards.
- R10: Only the last command sets the continuous bit, so its start request is 0x3. It has no receive phase, and the request rests at 0x2 once it is acknowledged.
- R11: Busy is 1 from reset until the continuous start is acknowledged, then 0, with the request word frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 3 | Engine status: bit0 send-ready, bit1 send-ack, bit2 send-done |
| result_i | input | NUM_DEV*WORD_W | Result words from the engine, converter d at bits d*WORD_W upward |
| req_o | output | 4 | Request: bit0 start, bit1 continuous, bit2 receive-ready, bit3 receive-ack |
| stat_clr_o | output | 1 | Clears the engine status register during power-up |
| cmd_o | output | NUM_DEV*WORD_W | Command words, one per converter |
| capt_o | output | NUM_DEV*WORD_W | Results latched at the last accepted send-done |
| delay_o | output | DELAY_W | Inter-sample delay value handed to the engine |
| busy_o | output | 1 | High until the continuous start is acknowledged |

## Verification
The hardest situations to reach from the ports are an engine that is slow to raise send-ready or to acknowledge, and a reset that lands in the middle of the long idle pause. The bench models the engine with adjustable latencies for ready, ack and done. It withholds ready for hundreds of cycles and stretches the ack so that it can watch start being held. It also forces a reset while the pause counter is running, and then checks that the whole script replays from the first command.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // request bit positions (decoded by the SPI engine)
   localparam int REQ_START = 0;
   localparam int REQ_CONT  = 1;
   localparam int REQ_RXRDY = 2;
   localparam int REQ_RXACK = 3;
   // status bit positions (driven by the SPI engine)
   localparam int ST_RDY  = 0;
   localparam int ST_ACK  = 1;
   localparam int ST_DONE = 2;

   localparam logic [7:0] OPC_RESET = 8'h85;
   localparam logic [7:0] OPC_AUTO  = 8'hA0;
   localparam logic [7:0] OPC_NOP   = 8'h00;
   localparam logic [6:0] PRG_AUTO_EN = 7'h01;
   localparam logic       PRG_WRITE   = 1'b1;

   typedef enum logic [2:0] {
      S_CLEAR, S_WAIT_RDY, S_ARM, S_WAIT_ACK, S_RX_ARM, S_WAIT_DONE, S_PAUSE, S_RUN
   } seq_state_e;

   typedef enum logic [1:0] {
      STEP_RESET, STEP_ENABLE, STEP_AUTO, STEP_START
   } seq_step_e;

   function automatic logic [15:0] cmd_reg_word(input logic [7:0] opcode);
      return {opcode, 8'h00};
   endfunction

   function automatic logic [15:0] prog_reg_word(input logic [6:0] addr,
                                                 input logic rw,
                                                 input logic [7:0] data);
      return {addr, rw, data};
   endfunction
endpackage

// File: rtl/adc_seq_word_enc.sv
module adc_seq_word_enc
   import adc_seq_pkg::*;
#(
   parameter int NUM_DEV = 6,
   parameter int WORD_W  = 16
) (
   input  seq_step_e                   step_i,
   output logic [NUM_DEV*WORD_W-1:0]   words_o
);
   logic [15:0] base;

   always_comb begin
      case (step_i)
         STEP_RESET:  base = cmd_reg_word(OPC_RESET);
         STEP_ENABLE: base = prog_reg_word(PRG_AUTO_EN, PRG_WRITE, 8'hFF);
         STEP_AUTO:   base = cmd_reg_word(OPC_AUTO);
         default:     base = cmd_reg_word(OPC_NOP);
      endcase
   end

   // every converter receives the identical word
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      assign words_o[d*WORD_W +: WORD_W] = WORD_W'(base);
   end
endmodule

// File: rtl/adc_seq_pause_timer.sv
module adc_seq_pause_timer #(
   parameter int PAUSE_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = $clog2(PAUSE_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PAUSE_CYC - 1);

   logic [CNT_W-1:0] cnt;

   if (PAUSE_CYC < 1) begin : g_bad_pause
      $error("PAUSE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run_i) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done_o = run_i && (cnt == LAST);

   AST_PAUSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R8
   AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt == '0)); // R8
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int NUM_DEV = 6,
   parameter int WORD_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en_i,
   input  logic [NUM_DEV*WORD_W-1:0]   data_i,
   output logic [NUM_DEV*WORD_W-1:0]   data_o
);
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    data_o[d*WORD_W +: WORD_W] <= '0;
         else if (en_i) data_o[d*WORD_W +: WORD_W] <= data_i[d*WORD_W +: WORD_W];
      end
   end

   AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(data_o)); // R5
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
   import adc_seq_pkg::*;
#(
   parameter int NUM_DEV    = 6,
   parameter int WORD_W     = 16,
   parameter int DELAY_W    = 16,
   parameter int INIT_DELAY = 781,
   parameter int PAUSE_CYC  = 200
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  status_i,
   input  logic [NUM_DEV*WORD_W-1:0]   result_i,
   output logic [3:0]                  req_o,
   output logic                        stat_clr_o,
   output logic [NUM_DEV*WORD_W-1:0]   cmd_o,
   output logic [NUM_DEV*WORD_W-1:0]   capt_o,
   output logic [DELAY_W-1:0]          delay_o,
   output logic                        busy_o
);
   localparam int BUS_W = NUM_DEV * WORD_W;
   localparam logic [DELAY_W-1:0] DELAY_INIT = DELAY_W'(INIT_DELAY);

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("NUM_DEV must be at least 1");
   end
   if (WORD_W < 16) begin : g_bad_word
      $error("WORD_W must hold a 16-bit command");
   end
   if (INIT_DELAY >= (1 << DELAY_W)) begin : g_bad_delay
      $error("INIT_DELAY does not fit DELAY_W");
   end

   seq_state_e        state;
   seq_step_e         step;
   logic [3:0]        req_q;
   logic [BUS_W-1:0]  cmd_q;
   logic [BUS_W-1:0]  enc_words;
   logic [DELAY_W-1:0] delay_q;
   logic              is_last;
   logic              tmr_done;
   logic              capt_en;

   assign is_last = (step == STEP_START);
   assign capt_en = (state == S_WAIT_DONE) && status_i[ST_DONE];

   adc_seq_word_enc #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) i_enc (
      .step_i  (step),
      .words_o (enc_words)
   );

   adc_seq_pause_timer #(.PAUSE_CYC(PAUSE_CYC)) i_pause (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == S_PAUSE),
      .done_o (tmr_done)
   );

   adc_seq_capture #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) i_capt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (capt_en),
      .data_i (result_i),
      .data_o (capt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_CLEAR;
         step    <= STEP_RESET;
         req_q   <= '0;
         cmd_q   <= '0;
         delay_q <= '0;
      end else begin
         case (state)
            S_CLEAR: state <= S_WAIT_RDY;
            S_WAIT_RDY: if (status_i[ST_RDY]) begin
               cmd_q <= enc_words;
               state <= S_ARM;
            end
            S_ARM: begin
               req_q <= {2'b00, is_last, 1'b1};
               state <= S_WAIT_ACK;
            end
            S_WAIT_ACK: if (status_i[ST_ACK]) begin
               req_q[REQ_START] <= 1'b0;
               state <= is_last ? S_RUN : S_RX_ARM;
            end
            S_RX_ARM: begin
               req_q[REQ_RXRDY] <= 1'b1;
               req_q[REQ_RXACK] <= 1'b0;
               state <= S_WAIT_DONE;
            end
            S_WAIT_DONE: if (status_i[ST_DONE]) begin
               req_q[REQ_RXRDY] <= 1'b0;
               req_q[REQ_RXACK] <= 1'b1;
               case (step)
                  STEP_RESET:  begin step <= STEP_ENABLE; state <= S_WAIT_RDY; end
                  STEP_ENABLE: state <= S_PAUSE;
                  default: begin
                     delay_q <= DELAY_INIT;
                     step    <= STEP_START;
                     state   <= S_WAIT_RDY;
                  end
               endcase
            end
            S_PAUSE: if (tmr_done) begin
               step  <= STEP_AUTO;
               state <= S_WAIT_RDY;
            end
            default: state <= S_RUN;
         endcase
      end
   end

   assign req_o      = req_q;
   assign stat_clr_o = (state == S_CLEAR);
   assign cmd_o      = cmd_q;
   assign delay_o    = delay_q;
   assign busy_o     = (state != S_RUN);

   AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[REQ_START] |=> $stable(cmd_q)); // R2
   AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[REQ_START] && !status_i[ST_ACK]) |=> req_q[REQ_START]); // R3
   AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[REQ_START] && status_i[ST_ACK]) |=> (!req_q[REQ_START] && $stable(req_q[REQ_CONT]))); // R3
   AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_q[REQ_START], req_q[REQ_RXRDY], req_q[REQ_RXACK]})); // R4
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[REQ_RXRDY] && !status_i[ST_DONE]) |=> req_q[REQ_RXRDY]); // R4
   AST_RX_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[REQ_RXRDY] && status_i[ST_DONE]) |=> (!req_q[REQ_RXRDY] && req_q[REQ_RXACK])); // R4
   AST_DELAY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(delay_q) |-> (delay_q == DELAY_INIT)); // R9
   AST_CONT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[REQ_CONT] |-> (step == STEP_START)); // R10
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> (!busy_o && $stable(req_q))); // R11
endmodule

// File: tb/test_adc_cmd_sequencer.sv
module test_adc_cmd_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NDEV  = 6;
   localparam int WW    = 16;
   localparam int PAUSE = 200;
   localparam int IDLY  = 781;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] status;
   logic [NDEV*WW-1:0] res_bus;
   logic [3:0] req;
   logic stat_clr;
   logic [NDEV*WW-1:0] cmd, capt;
   logic [15:0] delay;
   logic busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_cmd_sequencer #(.NUM_DEV(NDEV), .WORD_W(WW), .DELAY_W(16),
                       .INIT_DELAY(IDLY), .PAUSE_CYC(PAUSE)) i_adc_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .status_i(status), .result_i(res_bus),
      .req_o(req), .stat_clr_o(stat_clr), .cmd_o(cmd), .capt_o(capt),
      .delay_o(delay), .busy_o(busy));

   int n_chk = 0, n_fail = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int n, input int d);
      return 16'((n + 1) * 256 + d);
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- SPI engine model ----------------
   int lat_rdy = 0, lat_ack = 0, lat_done = 0;
   int eng_st, eng_cnt, nresp;
   bit cont_seen;

   always @(posedge clk) begin
      if (!rst_n || stat_clr) begin
         status <= '0; eng_st <= 0; eng_cnt <= 0; nresp <= 0; cont_seen <= 0;
      end else begin
         case (eng_st)
            0: if (!req[0]) begin
                  if (eng_cnt >= lat_rdy) status[0] <= 1'b1;
                  else eng_cnt <= eng_cnt + 1;
               end else begin
                  status[0] <= 1'b0; eng_cnt <= 0; eng_st <= 1; cont_seen <= req[1];
               end
            1: if (eng_cnt >= lat_ack) begin status[1] <= 1'b1; eng_st <= 2; end
               else eng_cnt <= eng_cnt + 1;
            2: if (!req[0]) begin
                  status[1] <= 1'b0; eng_cnt <= 0; eng_st <= cont_seen ? 5 : 3;
               end
            3: if (req[2]) begin
                  if (eng_cnt >= lat_done) begin
                     status[2] <= 1'b1;
                     for (int d = 0; d < NDEV; d++) res_bus[d*WW +: WW] <= pat(nresp, d);
                     eng_st <= 4;
                  end else eng_cnt <= eng_cnt + 1;
               end
            4: if (req[3]) begin
                  status[2] <= 1'b0; eng_cnt <= 0; nresp <= nresp + 1; eng_st <= 0;
               end
            default: ;
         endcase
      end
   end

   initial res_bus = '0;

   // ---------------- monitor ----------------
   logic [3:0]  prev_req;
   int          ncmd, nrx;
   logic [15:0] log_w [4][NDEV];
   bit          log_c [4];
   logic [15:0] log_d [4];
   int          log_cyc [4];
   int          rx_cyc [4];

   always @(negedge clk) begin
      if (!rst_n) prev_req = '0;
      else begin
         if (req[0] && !prev_req[0]) begin
            if (ncmd < 4) begin
               for (int d = 0; d < NDEV; d++) log_w[ncmd][d] = cmd[d*WW +: WW];
               log_c[ncmd] = req[1]; log_d[ncmd] = delay; log_cyc[ncmd] = cyc;
            end
            chk(req[3:2] == 2'b00, "R4", "rx bits at start", req, {2'b00, req[1:0]});
            ncmd++;
         end
         if (req[2] && !prev_req[2])
            chk(req == 4'h4, "R4", "request on receive-ready", req, 4'h4);
         if (req[3] && !prev_req[3]) begin
            chk(req == 4'h8, "R4", "request on receive-ack", req, 4'h8);
            for (int d = 0; d < NDEV; d++)
               chk(capt[d*WW +: WW] == pat(nresp, d), "R5", "captured result",
                   capt[d*WW +: WW], pat(nresp, d));
            if (nrx < 4) rx_cyc[nrx] = cyc;
            nrx++;
         end
         prev_req = req;
      end
   end

   // ---------------- tasks ----------------
   task automatic do_reset(input int lr, input int la, input int ld);
      rst_n = 1'b0;
      lat_rdy = lr; lat_ack = la; lat_done = ld;
      ncmd = 0; nrx = 0;
      repeat (3) @(negedge clk);
      chk(req == 4'h0, "R1", "request in reset", req, 0);
      chk(stat_clr == 1'b1, "R1", "status clear in reset", stat_clr, 1);
      chk(busy == 1'b1 && delay == 16'd0 && capt == '0, "R1", "busy/delay/capt in reset",
          {busy, delay}, {1'b1, 16'd0});
      rst_n = 1'b1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_sequence(input bit fast);
      logic [15:0] exp_w [4];
      exp_w[0] = 16'(8'h85) << 8;
      exp_w[1] = 16'((1 << 9) | (1 << 8) | 8'hFF);
      exp_w[2] = 16'(8'hA0) << 8;
      exp_w[3] = 16'h0000;
      chk(ncmd == 4, "R7", "command count", ncmd, 4);
      chk(nrx == 3, "R10", "receive phases", nrx, 3);
      for (int k = 0; k < 4; k++) begin
         bit same = 1'b1;
         for (int d = 0; d < NDEV; d++) if (log_w[k][d] != exp_w[k]) same = 1'b0;
         chk(same, "R6", $sformatf("word of command %0d on all devices (R7)", k),
             log_w[k][NDEV-1], exp_w[k]);
         chk(log_c[k] == (k == 3), "R10", $sformatf("continuous bit of command %0d", k),
             log_c[k], k == 3);
         chk(log_d[k] == ((k == 3) ? 16'(IDLY) : 16'd0), "R9",
             $sformatf("delay at command %0d", k), log_d[k], (k == 3) ? IDLY : 0);
      end
      chk(log_cyc[2] - rx_cyc[1] >= PAUSE, "R8", "pause lower bound",
          log_cyc[2] - rx_cyc[1], PAUSE);
      if (fast)
         chk(log_cyc[2] - rx_cyc[1] <= PAUSE + 8, "R8", "pause upper bound",
             log_cyc[2] - rx_cyc[1], PAUSE + 8);
      chk(req == 4'h2, "R10", "resting request", req, 4'h2);
      chk(busy == 1'b0, "R11", "busy after continuous ack", busy, 0);
      chk(delay == 16'(IDLY), "R9", "final delay", delay, IDLY);
      for (int d = 0; d < NDEV; d++)
         chk(capt[d*WW +: WW] == pat(2, d), "R5", "final captured word",
             capt[d*WW +: WW], pat(2, d));
   endtask

   task automatic t_reset_state();
      do_reset(0, 0, 0);
      @(negedge clk);
      chk(stat_clr == 1'b0 && req == 4'h0, "R1", "clear pulse ends after first cycle",
          {stat_clr, req}, 0);
   endtask

   task automatic t_fast_engine();
      do_reset(0, 0, 0);
      wait_idle();
      check_sequence(1'b1);
      repeat (20) @(negedge clk);
      chk(req == 4'h2 && busy == 1'b0, "R11", "request frozen when idle", req, 4'h2);
   endtask

   task automatic t_slow_ready();
      do_reset(300, 3, 5);
      repeat (250) @(negedge clk);
      chk(req == 4'h0 && busy == 1'b1, "R2", "no start before send-ready", req, 0);
      wait_idle();
      check_sequence(1'b0);
   endtask

   task automatic t_ack_hold();
      do_reset(2, 20, 4);
      for (int i = 0; i < 2000 && ncmd == 0; i++) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(req == 4'h1, "R3", "start held while ack pending", req, 4'h1);
      wait_idle();
      check_sequence(1'b0);
   endtask

   task automatic t_reset_in_pause();
      do_reset(0, 0, 0);
      for (int i = 0; i < 2000 && nrx < 2; i++) @(negedge clk);
      repeat (50) @(negedge clk);
      chk(ncmd == 2 && busy == 1'b1, "R8", "still pausing before reset", ncmd, 2);
      do_reset(1, 1, 1);
      wait_idle();
      check_sequence(1'b1);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      t_reset_state();
      t_fast_engine();
      t_slow_ready();
      t_ack_hold();
      t_reset_in_pause();
      report();
   end
endmodule